// File: doc/BRIEF.md
# Keyword Posterior Smoother and Phrase Decider

This block turns a stream of per-frame class probabilities into one detection flag per keyword for the current phrase. A new probability vector arrives every 10 ms with a valid strobe. The vector holds one unsigned fixed-point field per class. There are NUM_KW keyword classes, followed by an out-of-vocabulary class and a silence class. Only the keyword classes lead to an output.

Each keyword lane runs two cascaded window averages. The first is a moving average over SMOOTH_LEN frames. Because that window is centred on the frame it smooths, its result trails the input by (SMOOTH_LEN-1)/2 frames. The second stage averages the smoothed values over the last TRAIL_LEN frames. When that average exceeds a programmable threshold, the keyword's flag is latched. It stays latched until the next phrase start.

Both averages are held as running sums in circular buffers, so no division is done. The lane compares the second running sum against threshold x SMOOTH_LEN x TRAIL_LEN, which gives the same decision as comparing the averages exactly. A phrase-start pulse empties both windows and drops the flags. Windows that are only partly filled count the missing frames as zero. SMOOTH_LEN must be odd.

Top module: `kwd_decider`

## Requirements
- R1: After reset, every bit of `kw_detect` is 0.
- R2: Keyword k takes its probability from bits [k*PROB_W +: PROB_W] of `frame_prob`. The two fields above the keywords hold the out-of-vocabulary and silence classes. Those two fields have no effect on any output.
- R3: The first-stage sum for a keyword is the sum of its probabilities over the most recent SMOOTH_LEN accepted frames. Frames before the phrase start count as zero.
- R4: The second-stage sum is the sum of the most recent TRAIL_LEN first-stage sums, including the one formed by the current frame. Frames before the phrase start count as zero. An accepted frame sets the keyword's flag when this sum is strictly greater than `threshold` x SMOOTH_LEN x TRAIL_LEN. Equality does not set it.
- R5: A flag set by a frame accepted on a clock edge is visible on `kw_detect` immediately after that edge.
- R6: Once set, a flag stays at 1 until a phrase start, whatever frames follow.
- R7: `phrase_start` clears all flags, sums and window contents at the next edge. A frame presented in the same cycle is discarded.
- R8: In cycles without `frame_valid`, nothing changes: not the flags and not the sums. This holds even when `threshold` changes.
- R9: The running sums never exceed window length x the largest input value, so they cannot wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phrase_start | input | 1 | Begins a new phrase; clears all state |
| frame_valid | input | 1 | frame_prob holds a new frame this cycle |
| frame_prob | input | (NUM_KW+2)*PROB_W | Per-class probabilities, keyword 0 in the low field |
| threshold | input | PROB_W | Decision threshold in the same scale as a probability |
| kw_detect | output | NUM_KW | Latched per-keyword phrase decision |

## Verification
The bench builds the block with three keywords, 8-bit probabilities, SMOOTH_LEN of 5 and TRAIL_LEN of 3. With these values the circular buffers fill and wrap within a few frames, and zero-padded partial windows, full windows and pointer wraparound all occur many times in each phrase. A small window product of 15 also lets a directed case place the second-stage sum exactly on the threshold boundary, once at equality and once one step above it. Random phrases with varied thresholds and levels then exercise lanes that latch at different frames.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    // Width needed to hold the sum of depth values of in_w bits each.
    function automatic int sum_width(input int in_w, input int depth);
        return in_w + $clog2(depth + 1);
    endfunction

    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/kwd_window_sum.sv
module kwd_window_sum
    import kwd_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int DEPTH = 5,
    localparam int SUM_W = sum_width(IN_W, DEPTH),
    localparam int PTR_W = ptr_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [IN_W-1:0]  din,
    output logic [SUM_W-1:0] sum_o,
    output logic [SUM_W-1:0] sum_next_o
);

    localparam longint MAX_SUM = ((longint'(1) << IN_W) - 1) * DEPTH;

    typedef struct packed {
        logic [DEPTH-1:0][IN_W-1:0] ring;
        logic [PTR_W-1:0]           ptr;
        logic [SUM_W-1:0]           sum;
    } win_t;

    win_t            st_d, st_q;
    logic [IN_W-1:0] oldest;

    always_comb begin
        st_d   = st_q;
        oldest = st_q.ring[st_q.ptr];
        if (clr) begin
            st_d = '0;
        end else if (push) begin
            st_d.ring[st_q.ptr] = din;
            st_d.sum = st_q.sum + SUM_W'(din) - SUM_W'(oldest);
            if (st_q.ptr == PTR_W'(DEPTH - 1))
                st_d.ptr = '0;
            else
                st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o      = st_q.sum;
    assign sum_next_o = st_d.sum;

    assert_sum_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        longint'(sum_o) <= MAX_SUM);

    assert_window_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_o == '0));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !push) |=> $stable(sum_o));

endmodule

// File: rtl/kwd_lane.sv
module kwd_lane
    import kwd_pkg::*;
#(
    parameter int PROB_W     = 8,
    parameter int SMOOTH_LEN = 49,
    parameter int TRAIL_LEN  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [PROB_W-1:0] prob,
    input  logic [PROB_W-1:0] thr,
    output logic              det
);

    localparam int S1_W  = sum_width(PROB_W, SMOOTH_LEN);
    localparam int S2_W  = sum_width(S1_W, TRAIL_LEN);
    localparam int SPAN  = SMOOTH_LEN * TRAIL_LEN;
    localparam int THR_W = PROB_W + $clog2(SPAN + 1);
    localparam int CMP_W = max_int(S2_W, THR_W) + 1;

    typedef struct packed {
        logic det;
    } lane_t;

    lane_t            st_d, st_q;
    logic [S1_W-1:0]  s1_sum, s1_next;
    logic [S2_W-1:0]  s2_sum, s2_next;
    logic [CMP_W-1:0] thr_scaled;
    logic             over;

    kwd_window_sum #(.IN_W(PROB_W), .DEPTH(SMOOTH_LEN)) u_smooth (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .push       (push),
        .din        (prob),
        .sum_o      (s1_sum),
        .sum_next_o (s1_next)
    );

    kwd_window_sum #(.IN_W(S1_W), .DEPTH(TRAIL_LEN)) u_trail (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .push       (push),
        .din        (s1_next),
        .sum_o      (s2_sum),
        .sum_next_o (s2_next)
    );

    always_comb begin
        thr_scaled = CMP_W'(thr) * CMP_W'(SPAN);
        over       = CMP_W'(s2_next) > thr_scaled;
        st_d       = st_q;
        if (clr)
            st_d.det = 1'b0;
        else if (push && over)
            st_d.det = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign det = st_q.det;

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (det && !clr) |=> det);

    assert_flag_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !det);

    assert_no_frame_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!det && !push) |=> !det);

    assert_stage_sums_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !clr) |=> ($stable(s1_sum) && $stable(s2_sum)));

endmodule

// File: rtl/kwd_decider.sv
module kwd_decider #(
    parameter int NUM_KW     = 10,
    parameter int PROB_W     = 8,
    parameter int SMOOTH_LEN = 49,
    parameter int TRAIL_LEN  = 25
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           phrase_start,
    input  logic                           frame_valid,
    input  logic [(NUM_KW+2)*PROB_W-1:0]   frame_prob,
    input  logic [PROB_W-1:0]              threshold,
    output logic [NUM_KW-1:0]              kw_detect
);

    localparam int NUM_CLASS = NUM_KW + 2;

    logic push;
    assign push = frame_valid && !phrase_start;

    for (genvar k = 0; k < NUM_KW; k++) begin : g_lane
        kwd_lane #(
            .PROB_W     (PROB_W),
            .SMOOTH_LEN (SMOOTH_LEN),
            .TRAIL_LEN  (TRAIL_LEN)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (phrase_start),
            .push  (push),
            .prob  (frame_prob[k*PROB_W +: PROB_W]),
            .thr   (threshold),
            .det   (kw_detect[k])
        );
    end

    assert_frame_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> !$isunknown(frame_prob[NUM_CLASS*PROB_W-1:0]));

    assert_start_drops_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phrase_start |=> (kw_detect == '0));

endmodule

// File: tb/kwd_decider_bench.sv
module kwd_decider_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NK = 3;
    localparam int PW = 8;
    localparam int WS = 5;
    localparam int WC = 3;
    localparam int MAXF = 512;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    phrase_start = 1'b0;
    logic                    frame_valid = 1'b0;
    logic [(NK+2)*PW-1:0]    frame_prob = '0;
    logic [PW-1:0]           threshold = '0;
    logic [NK-1:0]           kw_detect;

    int vectors = 0;
    int miscompares = 0;
    int nf = 0;
    int hist [NK][MAXF];
    logic [NK-1:0] exp_det = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kwd_decider #(.NUM_KW(NK), .PROB_W(PW), .SMOOTH_LEN(WS), .TRAIL_LEN(WC)) u_kwd_decider (
        .clk          (clk),
        .rst_n        (rst_n),
        .phrase_start (phrase_start),
        .frame_valid  (frame_valid),
        .frame_prob   (frame_prob),
        .threshold    (threshold),
        .kw_detect    (kw_detect)
    );

    function automatic int exp_sum2(input int k);
        int s = 0;
        for (int j = 0; j < WC; j++)
            for (int m = 0; m < WS; m++) begin
                int idx = nf - 1 - j - m;
                if (idx >= 0) s += hist[k][idx];
            end
        return s;
    endfunction

    task automatic check(input string req);
        vectors++;
        if (kw_detect !== exp_det) begin
            miscompares++;
            $display("FAIL %s: kw_detect actual %b expected %b", req, kw_detect, exp_det);
        end
    endtask

    // One cycle: drive at negedge, update model, check at the following negedge.
    task automatic step(input logic v, input logic ps, input int p [NK+2],
                        input int thr, input string req);
        frame_valid  = v;
        phrase_start = ps;
        threshold    = PW'(thr);
        for (int c = 0; c < NK + 2; c++) frame_prob[c*PW +: PW] = PW'(p[c]);
        @(negedge clk);
        if (ps) begin
            nf = 0;
            exp_det = '0;
        end else if (v) begin
            for (int k = 0; k < NK; k++) hist[k][nf] = p[k];
            nf++;
            for (int k = 0; k < NK; k++)
                if (exp_sum2(k) > thr * WS * WC) exp_det[k] = 1'b1;
        end
        frame_valid  = 1'b0;
        phrase_start = 1'b0;
        check(req);
    endtask

    task automatic frame_all(input int kv, input int fill, input int thr, input string req);
        int p [NK+2];
        for (int c = 0; c < NK; c++) p[c] = kv;
        p[NK] = fill;
        p[NK+1] = fill;
        step(1'b1, 1'b0, p, thr, req);
    endtask

    task automatic new_phrase();
        int p [NK+2];
        for (int c = 0; c < NK + 2; c++) p[c] = 0;
        step(1'b0, 1'b1, p, 0, "R7");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int seed;
        int p [NK+2];
        seed = 32'h5eed_0042;
        void'($urandom(seed));

        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2: ignored classes at full scale, keywords at zero, threshold 0.
        new_phrase();
        for (int i = 0; i < 10; i++) frame_all(0, 255, 0, "R2");

        // R4 boundary: constant 20, threshold 20 -> full sum equals 15*20, no set.
        new_phrase();
        for (int i = 0; i < 12; i++) frame_all(20, 0, 20, "R4");
        // One step above: a single 21 raises the sum above the bound (R3, R5).
        frame_all(21, 0, 20, "R5");

        // R6: zeros afterwards keep the flag.
        for (int i = 0; i < 10; i++) frame_all(0, 0, 20, "R6");

        // R8: threshold drops to 0 with no frames; nothing changes.
        new_phrase();
        frame_all(1, 0, 200, "R3");
        for (int i = 0; i < 4; i++) begin
            for (int c = 0; c < NK + 2; c++) p[c] = 0;
            step(1'b0, 1'b0, p, 0, "R8");
        end

        // R7: phrase start with a strong frame in the same cycle discards it.
        for (int c = 0; c < NK + 2; c++) p[c] = 255;
        step(1'b1, 1'b1, p, 0, "R7");
        frame_all(0, 0, 0, "R7");

        // Per-lane: only keyword 1 rises.
        new_phrase();
        for (int i = 0; i < 8; i++) begin
            p[0] = 10; p[1] = 90; p[2] = 30; p[3] = 200; p[4] = 200;
            step(1'b1, 1'b0, p, 50, "R4");
        end

        // Constrained random phrases.
        for (int ph = 0; ph < 200; ph++) begin
            int len = 5 + int'($urandom_range(40));
            int thr = int'($urandom_range(255));
            new_phrase();
            for (int i = 0; i < len; i++) begin
                logic v = ($urandom_range(3) != 0);
                for (int c = 0; c < NK + 2; c++) begin
                    int lvl = int'($urandom_range(3));
                    p[c] = (lvl == 0) ? int'($urandom_range(255)) :
                           (lvl == 1) ? thr : int'($urandom_range(thr));
                end
                if ($urandom_range(15) == 0) thr = int'($urandom_range(255));
                step(v, 1'b0, p, thr, "R3/R4 random");
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule